// File: doc/BRIEF.md
# ADC Power and Channel Sequencer

This block controls a multi-channel analog-to-digital converter. It drives the converter's power-down line and a one-hot channel select bus. When enabled it releases power-down, waits a programmable settling delay, then requests each channel in turn. It holds each request until the converter reports a valid conversion. After the last channel completes it gives a single-cycle pair-complete strobe to the downstream debounce logic.

Three operating modes are supported. In continuous mode the converter stays powered and the channel walk repeats with no gap. In low-power mode the converter is powered down after every completed pair and kept asleep for a programmable interval, which is up to 24 bits of clock cycles long. After that interval the settling delay runs again. In one-shot mode a single pair is taken, then the converter is powered down and a completion flag is raised until the enable is removed. If both one-shot and low-power are selected, one-shot takes priority.

Clearing the enable, or asserting the synchronous sequencer reset, returns the block to idle on the next clock edge.

Top module: `adc_pwr_seq`

## Requirements
- R1: After reset `adc_pd_o` is 1, `adc_sel_o` is all zero, and `pair_done_o` and `oneshot_done_o` are 0.
- R2: `adc_sel_o` is one-hot or all zero in every cycle. No select bit is ever 1 while `adc_pd_o` is 1, and `adc_pd_o` is never unknown.
- R3: Each time `adc_pd_o` falls, the first request follows after exactly `pwrup_dly_i`+1 cycles in which `adc_pd_o` is 0 and `adc_sel_o` is zero. That first request is channel 0, which is bit 0 of `adc_sel_o`.
- R4: Channels are requested in ascending index order, bit 0 first and bit 1 next. Each select is held until a cycle in which `adc_valid_i` is 1, and the next channel is selected in the following cycle.
- R5: `pair_done_o` is 1 for exactly one cycle. That cycle is the one after `adc_valid_i` is accepted on the last channel. In continuous mode (`oneshot_i`=0, `lowpwr_i`=0), channel 0 is selected again in that same cycle and `adc_pd_o` stays 0.
- R6: With `oneshot_i`=1, after one pair `adc_pd_o` returns to 1 and `oneshot_done_o` is 1 from the strobe cycle until the enable is cleared. No further select or strobe occurs in that time. One-shot takes priority over `lowpwr_i`.
- R7: In low-power mode, `adc_pd_o` is reasserted no later than 10 cycles after the last channel's select falls. In this design it is reasserted in the strobe cycle itself.
- R8: In low-power mode, `adc_pd_o` stays 1 for exactly `wake_ivl_i`+1 cycles, counted from the strobe cycle, and then the power-up delay of R3 follows. A value of 0 gives a single cycle.
- R9: When `enable_i` is 0 at a clock edge, the following cycle has `adc_pd_o`=1, `adc_sel_o`=0, `oneshot_done_o`=0 and no strobe.
- R10: While `fsm_rst_i` is 1 the block behaves as in R9, even if `enable_i` is 1. After `fsm_rst_i` is released with `enable_i` still 1, a fresh power-up per R3 begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsm_rst_i | input | 1 | Synchronous sequencer reset to idle |
| enable_i | input | 1 | Run enable |
| oneshot_i | input | 1 | Take one pair, then stop |
| lowpwr_i | input | 1 | Sleep between pairs |
| pwrup_dly_i | input | DLY_W (4) | Settling delay after power-down release |
| wake_ivl_i | input | WAKE_W (24) | Sleep interval in low-power mode |
| adc_valid_i | input | 1 | Converter reports a conversion for the selected channel |
| adc_pd_o | output | 1 | Converter power-down |
| adc_sel_o | output | NUM_CH (2) | One-hot channel request |
| pair_done_o | output | 1 | One-cycle strobe per completed channel walk |
| oneshot_done_o | output | 1 | One-shot completion flag |

## Verification
The bench builds the block with its default parameters: two channels, a 4-bit delay and a 24-bit interval. This keeps the select order and the one-hot rule visible on a two-bit bus. Settling delays of 0 to 3 and sleep intervals of 0 and 20 keep the exact cycle counts of R3 and R8 short, while still covering the zero-length edge of both timers. The full 24-bit interval is only reached through the shared timer's width. Continuous, low-power, one-shot, and one-shot combined with low-power runs are driven against a converter model that answers each request two cycles after it appears.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_PWRUP = 3'd1,
      ST_REQ   = 3'd2,
      ST_SLEEP = 3'd3,
      ST_DONE  = 3'd4
   } seq_state_e;

   function automatic int max_int(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/adc_seq_timer.sv
module adc_seq_timer #(
   parameter int W = 24
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_i,
   input  logic [W-1:0] val_i,
   output logic         zero_o
);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (load_i)         cnt_q <= val_i;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign zero_o = (cnt_q == '0);

   // R8: a load is visible on the following cycle
   assert_timer_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (cnt_q == $past(val_i)));

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
   import adc_seq_pkg::*;
#(
   parameter int NUM_CH = 2,
   parameter int WAKE_W = 24,
   localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fsm_rst_i,
   input  logic             enable_i,
   input  logic             oneshot_i,
   input  logic             lowpwr_i,
   input  logic [WAKE_W-1:0] wake_ivl_i,
   input  logic             valid_i,
   input  logic             tmr_zero_i,
   output seq_state_e       state_o,
   output logic [CH_W-1:0]  ch_o,
   output logic             tmr_load_o,
   output logic             tmr_wake_o,
   output logic             strobe_o
);

   localparam logic [CH_W-1:0] LAST_CH = CH_W'(NUM_CH - 1);

   seq_state_e      state_q, state_d;
   logic [CH_W-1:0] ch_q, ch_d;
   logic            strobe_q, strobe_d;
   logic            abort;

   assign abort = fsm_rst_i || !enable_i;

   always_comb begin
      state_d    = state_q;
      ch_d       = ch_q;
      strobe_d   = 1'b0;
      tmr_load_o = 1'b0;
      tmr_wake_o = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            state_d    = ST_PWRUP;
            tmr_load_o = 1'b1;
         end
         ST_PWRUP: begin
            if (tmr_zero_i) begin
               state_d = ST_REQ;
               ch_d    = '0;
            end
         end
         ST_REQ: begin
            if (valid_i) begin
               if (ch_q == LAST_CH) begin
                  strobe_d = 1'b1;
                  ch_d     = '0;
                  if (oneshot_i) begin
                     state_d = ST_DONE;
                  end else if (lowpwr_i) begin
                     state_d    = ST_SLEEP;
                     tmr_load_o = 1'b1;
                     tmr_wake_o = 1'b1;
                  end
               end else begin
                  ch_d = ch_q + 1'b1;
               end
            end
         end
         ST_SLEEP: begin
            if (tmr_zero_i) begin
               state_d    = ST_PWRUP;
               tmr_load_o = 1'b1;
            end
         end
         ST_DONE: state_d = ST_DONE;
         default: state_d = ST_IDLE;
      endcase
      if (abort) begin
         state_d    = ST_IDLE;
         ch_d       = '0;
         strobe_d   = 1'b0;
         tmr_load_o = 1'b0;
         tmr_wake_o = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         ch_q     <= '0;
         strobe_q <= 1'b0;
      end else begin
         state_q  <= state_d;
         ch_q     <= ch_d;
         strobe_q <= strobe_d;
      end
   end

   assign state_o  = state_q;
   assign ch_o     = ch_q;
   assign strobe_o = strobe_q;

   // Sleep-length checker: cycles spent in sleep versus captured interval
   logic [WAKE_W-1:0] sl_cnt_q, w_cap_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sl_cnt_q <= '0;
         w_cap_q  <= '0;
      end else begin
         if (state_q == ST_SLEEP) sl_cnt_q <= sl_cnt_q + 1'b1;
         else                     sl_cnt_q <= '0;
         if (tmr_wake_o)          w_cap_q  <= wake_ivl_i;
      end
   end

   assert_sleep_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_SLEEP && state_d == ST_PWRUP) |-> (sl_cnt_q == w_cap_q));

   assert_disable_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !enable_i |=> (state_q == ST_IDLE));

endmodule

// File: rtl/adc_pwr_seq.sv
module adc_pwr_seq
   import adc_seq_pkg::*;
#(
   parameter int NUM_CH = 2,
   parameter int DLY_W  = 4,
   parameter int WAKE_W = 24,
   parameter int LP_REENTRY_MAX = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fsm_rst_i,
   input  logic              enable_i,
   input  logic              oneshot_i,
   input  logic              lowpwr_i,
   input  logic [DLY_W-1:0]  pwrup_dly_i,
   input  logic [WAKE_W-1:0] wake_ivl_i,
   input  logic              adc_valid_i,
   output logic              adc_pd_o,
   output logic [NUM_CH-1:0] adc_sel_o,
   output logic              pair_done_o,
   output logic              oneshot_done_o
);

   localparam int TMR_W = max_int(DLY_W, WAKE_W);
   localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

   if (NUM_CH < 2)   begin : g_bad_ch   $error("NUM_CH must be at least 2"); end
   if (DLY_W < 1)    begin : g_bad_dly  $error("DLY_W must be at least 1"); end
   if (WAKE_W < 1)   begin : g_bad_wake $error("WAKE_W must be at least 1"); end

   seq_state_e      state;
   logic [CH_W-1:0] ch;
   logic            tmr_load, tmr_wake, tmr_zero;
   logic [TMR_W-1:0] tmr_val;

   assign tmr_val = tmr_wake ? TMR_W'(wake_ivl_i) : TMR_W'(pwrup_dly_i);

   adc_seq_fsm #(.NUM_CH(NUM_CH), .WAKE_W(WAKE_W)) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .fsm_rst_i  (fsm_rst_i),
      .enable_i   (enable_i),
      .oneshot_i  (oneshot_i),
      .lowpwr_i   (lowpwr_i),
      .wake_ivl_i (wake_ivl_i),
      .valid_i    (adc_valid_i),
      .tmr_zero_i (tmr_zero),
      .state_o    (state),
      .ch_o       (ch),
      .tmr_load_o (tmr_load),
      .tmr_wake_o (tmr_wake),
      .strobe_o   (pair_done_o)
   );

   adc_seq_timer #(.W(TMR_W)) u_tmr (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (tmr_load),
      .val_i  (tmr_val),
      .zero_o (tmr_zero)
   );

   assign adc_pd_o       = (state == ST_IDLE) || (state == ST_SLEEP) || (state == ST_DONE);
   assign oneshot_done_o = (state == ST_DONE);

   for (genvar i = 0; i < NUM_CH; i++) begin : g_sel
      assign adc_sel_o[i] = (state == ST_REQ) && (ch == CH_W'(i));
   end

   // ---------------- checkers ----------------
   assert_sel_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(adc_sel_o));

   assert_pd_known_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !$isunknown(adc_pd_o));

   assert_sel_pd_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
      adc_pd_o |-> (adc_sel_o == '0));

   assert_strobe_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      pair_done_o |=> !pair_done_o);

   assert_done_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      oneshot_done_o |-> (adc_pd_o && adc_sel_o == '0));

   assert_abort_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (fsm_rst_i || !enable_i) |=> (adc_pd_o && adc_sel_o == '0 && !oneshot_done_o && !pair_done_o));

   // Power-up delay checker (R3)
   logic [DLY_W:0]   pu_cnt_q;
   logic [DLY_W-1:0] d_cap_q;
   logic             pu_pend_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pu_cnt_q  <= '0;
         d_cap_q   <= '0;
         pu_pend_q <= 1'b0;
      end else if (adc_pd_o) begin
         pu_cnt_q  <= '0;
         d_cap_q   <= pwrup_dly_i;
         pu_pend_q <= 1'b1;
      end else if (pu_pend_q) begin
         pu_cnt_q  <= pu_cnt_q + 1'b1;
         if (adc_sel_o[0]) pu_pend_q <= 1'b0;
      end
   end

   assert_pwrup_delay_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (pu_pend_q && !adc_pd_o && adc_sel_o != '0) |->
         (adc_sel_o[0] && pu_cnt_q == ({1'b0, d_cap_q} + 1'b1)));

   // Low-power re-entry checker (R7)
   logic       last_sel_q;
   logic [4:0] lp_gap_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         last_sel_q <= 1'b0;
         lp_gap_q   <= '0;
      end else begin
         last_sel_q <= adc_sel_o[NUM_CH-1];
         if (!lowpwr_i || oneshot_i || adc_pd_o)           lp_gap_q <= '0;
         else if (last_sel_q && !adc_sel_o[NUM_CH-1])      lp_gap_q <= 5'd1;
         else if (lp_gap_q != '0 && lp_gap_q != 5'd31)     lp_gap_q <= lp_gap_q + 1'b1;
      end
   end

   assert_lp_reentry_R7: assert property (@(posedge clk) disable iff (!rst_n)
      lowpwr_i |-> (lp_gap_q <= 5'(LP_REENTRY_MAX)));

endmodule

// File: tb/sim_adc_pwr_seq.sv
module sim_adc_pwr_seq;

   localparam int CLK_PERIOD = 10;
   localparam int LAT        = 2;
   localparam int WD_LIMIT   = 20000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        fsm_rst = 1'b0;
   logic        enable = 1'b0;
   logic        oneshot = 1'b0;
   logic        lowpwr = 1'b0;
   logic [3:0]  pwrup_dly = '0;
   logic [23:0] wake_ivl = '0;
   logic        adc_valid = 1'b0;
   logic        adc_pd;
   logic [1:0]  adc_sel;
   logic        pair_done;
   logic        os_done;

   int n_run = 0;
   int n_fail = 0;
   int cyc = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   adc_pwr_seq u0 (
      .clk(clk), .rst_n(rst_n), .fsm_rst_i(fsm_rst), .enable_i(enable),
      .oneshot_i(oneshot), .lowpwr_i(lowpwr), .pwrup_dly_i(pwrup_dly),
      .wake_ivl_i(wake_ivl), .adc_valid_i(adc_valid), .adc_pd_o(adc_pd),
      .adc_sel_o(adc_sel), .pair_done_o(pair_done), .oneshot_done_o(os_done)
   );

   // Converter model: answers a request LAT cycles after it appears
   logic [1:0] m_prev = '0;
   int         m_cnt = 0;
   always @(negedge clk) begin
      if (adc_sel != m_prev) m_cnt = 0;
      else                   m_cnt = m_cnt + 1;
      adc_valid <= (adc_sel != '0) && (m_cnt >= LAT);
      m_prev = adc_sel;
   end

   always @(posedge clk) cyc <= cyc + 1;

   task automatic step();
      @(negedge clk);
   endtask

   task automatic check(input string req, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: got %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic measure_gap(output int gap);
      gap = 0;
      for (int g = 0; g < 100 && adc_sel == '0; g++) begin
         if (!adc_pd) gap++;
         step();
      end
   endtask

   task automatic wait_strobe();
      for (int g = 0; g < 200 && !pair_done; g++) step();
   endtask

   task automatic measure_pd_high(output int n);
      n = 0;
      for (int g = 0; g < 1000 && adc_pd; g++) begin
         n++;
         step();
      end
   endtask

   task automatic t_reset();
      check("R1 pd", int'(adc_pd), 1);
      check("R1 sel", int'(adc_sel), 0);
      check("R1 strobe", int'(pair_done), 0);
      check("R1 done", int'(os_done), 0);
   endtask

   task automatic t_oneshot();
      int gap, bad;
      oneshot = 1; lowpwr = 0; pwrup_dly = 4'd3;
      enable = 1; step();
      measure_gap(gap);
      check("R3 delay D=3", gap, 4);
      check("R4 first ch0", int'(adc_sel), 1);
      wait_strobe();
      check("R6 done at strobe", int'(os_done), 1);
      check("R6 pd at strobe", int'(adc_pd), 1);
      step();
      bad = 0;
      for (int k = 0; k < 30; k++) begin
         if (adc_sel != '0 || pair_done || !os_done || !adc_pd) bad++;
         step();
      end
      check("R6 quiet after one pair", bad, 0);
      enable = 0; step();
      check("R9 done cleared", int'(os_done), 0);
      check("R9 pd after disable", int'(adc_pd), 1);
      oneshot = 0;
   endtask

   task automatic t_normal_and_abort();
      int gap, strobes, order_err, pd_hi, strobe_err, onehot_err;
      logic [1:0] prev_nz;
      oneshot = 0; lowpwr = 0; pwrup_dly = 4'd0;
      enable = 1; step();
      measure_gap(gap);
      check("R3 delay D=0", gap, 1);
      strobes = 0; order_err = 0; pd_hi = 0; strobe_err = 0; onehot_err = 0;
      prev_nz = 2'b10;
      for (int k = 0; k < 80; k++) begin
         if (adc_sel != '0 && adc_sel != prev_nz) begin
            if (adc_sel != ((prev_nz == 2'b01) ? 2'b10 : 2'b01)) order_err++;
            prev_nz = adc_sel;
         end
         if (adc_sel == 2'b11) onehot_err++;
         if (adc_pd) pd_hi++;
         if (pair_done) begin
            strobes++;
            if (adc_sel != 2'b01) strobe_err++;
         end
         step();
      end
      check("R4 order ch0,ch1", order_err, 0);
      check("R2 one-hot", onehot_err, 0);
      check("R5 pd stays low", pd_hi, 0);
      check("R5 ch0 in strobe cycle", strobe_err, 0);
      check("R5 strobes seen", int'(strobes >= 3), 1);
      for (int g = 0; g < 20 && adc_sel != 2'b10; g++) step();
      enable = 0; step();
      check("R9 pd mid-request", int'(adc_pd), 1);
      check("R9 sel mid-request", int'(adc_sel), 0);
      check("R9 no strobe", int'(pair_done), 0);
   endtask

   task automatic t_lowpower(input int w, input int d);
      int n, gap;
      oneshot = 0; lowpwr = 1; pwrup_dly = 4'(d); wake_ivl = 24'(w);
      enable = 1; step();
      wait_strobe();
      check("R7 pd at strobe", int'(adc_pd), 1);
      measure_pd_high(n);
      check($sformatf("R8 sleep W=%0d", w), n, w + 1);
      measure_gap(gap);
      check("R3 delay after sleep", gap, d + 1);
      wait_strobe();
      check("R7 pd at second strobe", int'(adc_pd), 1);
      enable = 0; step(); step();
      lowpwr = 0;
   endtask

   task automatic t_priority();
      oneshot = 1; lowpwr = 1; pwrup_dly = 4'd1; wake_ivl = 24'd5;
      enable = 1; step();
      wait_strobe();
      step(); step(); step(); step(); step(); step(); step();
      check("R6 one-shot beats low-power", int'(os_done), 1);
      check("R6 no wakeup", int'(adc_sel), 0);
      enable = 0; step();
      oneshot = 0; lowpwr = 0;
   endtask

   task automatic t_fsm_rst();
      int bad, gap;
      oneshot = 0; lowpwr = 0; pwrup_dly = 4'd1;
      enable = 1; step();
      for (int g = 0; g < 20 && adc_sel != 2'b01; g++) step();
      fsm_rst = 1; step();
      bad = 0;
      for (int k = 0; k < 6; k++) begin
         if (!adc_pd || adc_sel != '0 || pair_done) bad++;
         step();
      end
      check("R10 held idle", bad, 0);
      fsm_rst = 0; step();
      measure_gap(gap);
      check("R10 restart delay", gap, 2);
      enable = 0; step();
   endtask

   initial begin
      repeat (3) step();
      rst_n = 1; step();
      t_reset();
      t_oneshot();
      t_normal_and_abort();
      t_lowpower(20, 2);
      t_lowpower(0, 0);
      t_priority();
      t_fsm_rst();
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      wait (cyc >= WD_LIMIT);
      if (!finished) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: got %0d cycles expected below %0d", cyc, WD_LIMIT);
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule